// File: doc/BRIEF.md
# Dual-Channel IDE Card Register Decoder

This block sits between a byte-wide host bus and the registers of a two-channel IDE expansion card. Each host access is captured by a small bus state machine, decoded against the card's address map, and turned into a one-cycle chip select for exactly one target. The targets are the eight taskfile registers of either channel, each channel's control/alternate-status register, each channel's interrupt mask and interrupt status registers, the card's own configuration byte and the four identity bits. The decoder owns only the configuration byte and the identity bits. The other targets are external, and the decoder only selects them.

The address space has two windows, chosen by the top address bit. The fast window (top bit 0) holds the configuration byte at offset 0 and the identity bits. The extended window (top bit 1) holds both channels' registers. The extended window decodes only while the enable bit of the configuration byte is set. Clearing that byte closes the extended window and makes the identity bits readable again, which matters after a soft restart. Another configuration bit steers the card's DMA request/acknowledge pair to one channel or the other.

The bus state machine has three states. IDLE waits for a strobe. SELECT asserts the chosen select for one cycle. HOLD waits for the host to release a strobe that is still asserted. The transitions are:
- IDLE to SELECT when exactly one strobe is high.
- SELECT to IDLE when both strobes are low.
- SELECT to HOLD when a strobe is still high.
- HOLD to IDLE once both strobes are low.

Top module: `ide_card_decoder`

## Requirements
- R1: After reset the configuration byte is 0, `dma_route` and `ext_en` are 0, and `cs_vec` is 0.
- R2: A strobe seen at a rising edge in IDLE gives exactly one select cycle, in the cycle after that edge. A strobe held longer gives no further select until both strobes have been low. A cycle with read and write both high starts no access and changes nothing.
- R3: `cs_vec` has at most one bit set. Its bit order is 0 configuration, 1 identity, 2 taskfile ch0, 3 taskfile ch1, 4 control ch0, 5 control ch1, 6 interrupt mask ch0, 7 interrupt mask ch1, 8 interrupt status ch0, 9 interrupt status ch1. An undecoded address sets no bit and reads back 0.
- R4: The configuration byte sits at fast-window offset 0 and is readable and writable. A write takes effect at the end of its select cycle. A read returns the stored byte on `bus_rdata` during the select cycle.
- R5: Configuration bit 0 drives `dma_route`: 0 steers DMA to channel 0, 1 steers it to channel 1.
- R6: Configuration bit 5 drives `ext_en`. While it is 0, no extended-window access asserts any select, and writing 0 to the configuration byte closes the window.
- R7: The taskfile of channel c starts at extended offset 0x2000 + c·0x1000. Register n (0..7) sits at base + n·64, and `sel_index` = n during its select. Offsets inside that span that are not multiples of 64 are undecoded.
- R8: Relative to each channel's base, the interrupt mask is at 0x200, the interrupt status at 0x290 and the control register at 0x380, all in the extended window.
- R9: Reads at fast offsets 0x2280 + 4k (k = 0..3) select the identity target. They return bit k of the card type in data bit 0, with the other bits 0. The card type defaults to 3. These reads decode only while configuration bit 5 is 0. Writes to these offsets select nothing.
- R10: Reads of external targets (taskfile, control, interrupt) return 0 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 15 | Host address; bit 14 selects the extended window |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for block-owned registers, else 0 |
| cs_vec | output | 10 | One-cycle chip selects, bit order per R3 |
| sel_index | output | 3 | Taskfile register number during a taskfile select |
| dma_route | output | 1 | DMA signal steering to channel 0 or 1 |
| ext_en | output | 1 | Extended window enabled |

## Verification
A wrong state in the bus machine shows at the ports within one cycle of a strobe. It appears as a select that is missing, arrives a cycle late, or repeats while the strobe is held. A corrupted configuration byte shows when the next read of offset 0 returns the wrong value, and directly on `dma_route` and `ext_en`. A wrong stored target shows as the wrong `cs_vec` bit or `sel_index` in the select cycle. A gating error shows as a select or identity data appearing in the wrong configuration state.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_CFG,
        TGT_IDENT,
        TGT_TF0,
        TGT_TF1,
        TGT_CTL0,
        TGT_CTL1,
        TGT_IRQ0,
        TGT_IRQ1,
        TGT_IST0,
        TGT_IST1
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_HOLD
    } bus_st_e;

    localparam int NUM_SEL = 10;

endpackage

// File: rtl/ide_bus_fsm.sv
module ide_bus_fsm
    import ide_dec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd,
    input  logic    wr,
    output bus_st_e st,
    output logic    start
);

    bus_st_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (rd ^ wr)    st_nx = ST_SELECT;
            ST_SELECT: st_nx = (rd | wr) ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (!(rd | wr)) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    assign start = (st == ST_IDLE) && (rd ^ wr);

endmodule

// File: rtl/ide_cfg_reg.sv
module ide_cfg_reg #(
    parameter int DATA_W    = 8,
    parameter int EXT_BIT   = 5,
    parameter int ROUTE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic              ext_en,
    output logic              dma_route
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata;
    end

    assign ext_en    = cfg_q[EXT_BIT];
    assign dma_route = cfg_q[ROUTE_BIT];

endmodule

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int STRIDE_LOG2  = 6,
    parameter int TF_REGS      = 8,
    parameter int CH_SPAN_LOG2 = 12,
    parameter int CH0_BASE     = 'h2000,
    parameter int IRQ_REL      = 'h200,
    parameter int IST_REL      = 'h290,
    parameter int CTL_REL      = 'h380,
    parameter int IDENT_BASE   = 'h2280,
    localparam int OFF_W       = ADDR_W - 1,
    localparam int IDX_W       = $clog2(TF_REGS),
    localparam int HI_W        = OFF_W - CH_SPAN_LOG2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              ext_en,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  tf_idx,
    output logic [1:0]        ident_k
);

    localparam int NUM_CH = 2;
    localparam logic [CH_SPAN_LOG2-1:0] TF_LIM = CH_SPAN_LOG2'(TF_REGS << STRIDE_LOG2);
    localparam logic [CH_SPAN_LOG2-1:0] IRQ_R  = CH_SPAN_LOG2'(IRQ_REL);
    localparam logic [CH_SPAN_LOG2-1:0] IST_R  = CH_SPAN_LOG2'(IST_REL);
    localparam logic [CH_SPAN_LOG2-1:0] CTL_R  = CH_SPAN_LOG2'(CTL_REL);
    localparam logic [OFF_W-5:0]        ID_KEY = (OFF_W-4)'(IDENT_BASE >> 4);

    logic             win_ext;
    logic [OFF_W-1:0] off;
    logic             ident_hit;

    assign win_ext   = addr[ADDR_W-1];
    assign off       = addr[OFF_W-1:0];
    assign ident_hit = (off[OFF_W-1:4] == ID_KEY) && (off[1:0] == 2'b00);

    logic [NUM_CH-1:0] ch_tf, ch_ctl, ch_irq, ch_ist;
    logic [IDX_W-1:0]  ch_idx [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [HI_W-1:0] KEY = HI_W'((CH0_BASE >> CH_SPAN_LOG2) + c);
        logic                    hit;
        logic [CH_SPAN_LOG2-1:0] rel;
        assign hit       = (off[OFF_W-1:CH_SPAN_LOG2] == KEY);
        assign rel       = off[CH_SPAN_LOG2-1:0];
        assign ch_tf[c]  = hit && (rel < TF_LIM) && (rel[STRIDE_LOG2-1:0] == '0);
        assign ch_irq[c] = hit && (rel == IRQ_R);
        assign ch_ist[c] = hit && (rel == IST_R);
        assign ch_ctl[c] = hit && (rel == CTL_R);
        assign ch_idx[c] = rel[STRIDE_LOG2 +: IDX_W];
    end

    always_comb begin
        tgt     = TGT_NONE;
        tf_idx  = '0;
        ident_k = '0;
        if (!win_ext) begin
            if (off == '0) begin
                tgt = TGT_CFG;
            end else if (ident_hit && !ext_en && !is_write) begin
                tgt     = TGT_IDENT;
                ident_k = off[3:2];
            end
        end else if (ext_en) begin
            if (ch_tf[0]) begin
                tgt    = TGT_TF0;
                tf_idx = ch_idx[0];
            end else if (ch_tf[1]) begin
                tgt    = TGT_TF1;
                tf_idx = ch_idx[1];
            end else if (ch_ctl[0]) tgt = TGT_CTL0;
            else if (ch_ctl[1])     tgt = TGT_CTL1;
            else if (ch_irq[0])     tgt = TGT_IRQ0;
            else if (ch_irq[1])     tgt = TGT_IRQ1;
            else if (ch_ist[0])     tgt = TGT_IST0;
            else if (ch_ist[1])     tgt = TGT_IST1;
        end
    end

endmodule

// File: rtl/ide_card_decoder.sv
module ide_card_decoder
    import ide_dec_pkg::*;
#(
    parameter int          ADDR_W      = 15,
    parameter int          DATA_W      = 8,
    parameter int          STRIDE_LOG2 = 6,
    parameter int          TF_REGS     = 8,
    parameter logic [3:0]  CARD_TYPE   = 4'd3,
    localparam int         IDX_W       = $clog2(TF_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_SEL-1:0] cs_vec,
    output logic [IDX_W-1:0]   sel_index,
    output logic               dma_route,
    output logic               ext_en
);

    bus_st_e          st;
    logic             start;
    tgt_e             tgt_d, tgt_q;
    logic [IDX_W-1:0] idx_d, idx_q;
    logic [1:0]       id_d, id_q;
    logic             wr_q;
    logic [DATA_W-1:0] wdata_q, cfg_q;
    logic             cfg_we;

    ide_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .st    (st),
        .start (start)
    );

    ide_addr_decode #(
        .ADDR_W      (ADDR_W),
        .STRIDE_LOG2 (STRIDE_LOG2),
        .TF_REGS     (TF_REGS)
    ) u_dec (
        .addr     (bus_addr),
        .is_write (bus_wr),
        .ext_en   (ext_en),
        .tgt      (tgt_d),
        .tf_idx   (idx_d),
        .ident_k  (id_d)
    );

    assign cfg_we = (st == ST_SELECT) && (tgt_q == TGT_CFG) && wr_q;

    ide_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wdata     (wdata_q),
        .cfg_q     (cfg_q),
        .ext_en    (ext_en),
        .dma_route (dma_route)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= TGT_NONE;
            idx_q   <= '0;
            id_q    <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            tgt_q   <= tgt_d;
            idx_q   <= idx_d;
            id_q    <= id_d;
            wr_q    <= bus_wr;
            wdata_q <= bus_wdata;
        end
    end

    always_comb begin
        cs_vec    = '0;
        sel_index = '0;
        bus_rdata = '0;
        if (st == ST_SELECT) begin
            unique case (tgt_q)
                TGT_CFG:   begin
                    cs_vec[0] = 1'b1;
                    if (!wr_q) bus_rdata = cfg_q;
                end
                TGT_IDENT: begin
                    cs_vec[1] = 1'b1;
                    bus_rdata = DATA_W'(CARD_TYPE[id_q]);
                end
                TGT_TF0:   begin cs_vec[2] = 1'b1; sel_index = idx_q; end
                TGT_TF1:   begin cs_vec[3] = 1'b1; sel_index = idx_q; end
                TGT_CTL0:  cs_vec[4] = 1'b1;
                TGT_CTL1:  cs_vec[5] = 1'b1;
                TGT_IRQ0:  cs_vec[6] = 1'b1;
                TGT_IRQ1:  cs_vec[7] = 1'b1;
                TGT_IST0:  cs_vec[8] = 1'b1;
                TGT_IST1:  cs_vec[9] = 1'b1;
                default:   cs_vec = '0;
            endcase
        end
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_vec));

    // R2
    sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_vec != '0) |=> (cs_vec == '0));

    // R2
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (cs_vec == '0));

    // R6
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_vec[NUM_SEL-1:2] != '0) |-> ext_en);

    // R9
    ident_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_vec[1] |-> !ext_en);

    // R4
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(cs_vec[0] && wr_q));

    // R7
    idx_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_index != '0) |-> (cs_vec[2] || cs_vec[3]));

endmodule

// File: tb/sim_ide_card_decoder.sv
module sim_ide_card_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [9:0]  cs_vec;
    logic [2:0]  sel_index;
    logic        dma_route;
    logic        ext_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [14:0] EXT = 15'h4000;

    always #5 clk = ~clk;

    ide_card_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cs_vec    (cs_vec),
        .sel_index (sel_index),
        .dma_route (dma_route),
        .ext_en    (ext_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one access; samples in the select cycle, counts select cycles seen
    task automatic acc(input logic w, input logic [14:0] a, input logic [7:0] d,
                       input int hold, output logic [9:0] cs,
                       output logic [7:0] rdat, output logic [2:0] ix,
                       output int nsel);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = !w;
        @(posedge clk);
        @(negedge clk);
        cs = cs_vec; rdat = bus_rdata; ix = sel_index;
        nsel = (cs_vec != '0) ? 1 : 0;
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            if (cs_vec != '0) nsel++;
        end
        bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        if (cs_vec != '0) nsel++;
    endtask

    task automatic t_reset;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        check("R1", "cs after reset", 32'(cs_vec), 0);
        check("R1", "dma_route after reset", 32'(dma_route), 0);
        check("R1", "ext_en after reset", 32'(ext_en), 0);
        acc(1'b0, 15'h0000, 8'h00, 1, cs, rd, ix, ns);
        check("R1", "cfg readback after reset", 32'(rd), 0);
        check("R4", "cfg select bit", 32'(cs), 32'h001);
    endtask

    task automatic t_ident;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        logic [3:0] ty;
        ty = '0;
        for (int k = 0; k < 4; k++) begin
            acc(1'b0, 15'h2280 + 15'(4*k), 8'h00, 1, cs, rd, ix, ns);
            check("R9", "ident select", 32'(cs), 32'h002);
            check("R9", "ident upper bits", 32'(rd[7:1]), 0);
            ty[k] = rd[0];
        end
        check("R9", "assembled card type", 32'(ty), 3);
        acc(1'b1, 15'h2284, 8'hFF, 1, cs, rd, ix, ns);
        check("R9", "write to ident selects nothing", 32'(cs), 0);
    endtask

    task automatic t_ext_gated;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        acc(1'b0, EXT | 15'h2000, 8'h00, 1, cs, rd, ix, ns);
        check("R6", "taskfile while window closed", 32'(cs), 0);
        acc(1'b1, EXT | 15'h3380, 8'h55, 1, cs, rd, ix, ns);
        check("R6", "control write while window closed", 32'(cs), 0);
    endtask

    task automatic t_cfg;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        acc(1'b1, 15'h0000, 8'h21, 1, cs, rd, ix, ns);
        check("R4", "cfg write select", 32'(cs), 32'h001);
        check("R5", "route after 0x21", 32'(dma_route), 1);
        check("R6", "ext_en after 0x21", 32'(ext_en), 1);
        acc(1'b0, 15'h0000, 8'h00, 1, cs, rd, ix, ns);
        check("R4", "cfg readback", 32'(rd), 32'h21);
        acc(1'b1, 15'h0000, 8'h20, 1, cs, rd, ix, ns);
        check("R5", "route after 0x20", 32'(dma_route), 0);
        check("R6", "ext_en kept", 32'(ext_en), 1);
        acc(1'b0, 15'h2288, 8'h00, 1, cs, rd, ix, ns);
        check("R9", "ident blocked while window open", 32'(cs), 0);
        check("R9", "ident blocked data", 32'(rd), 0);
    endtask

    task automatic t_taskfile;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 8; r++) begin
                acc(1'b0, EXT | (15'h2000 + 15'(c * 'h1000) + 15'(r * 64)),
                    8'h00, 1, cs, rd, ix, ns);
                check("R7", "taskfile select", 32'(cs), 32'(1 << (2 + c)));
                check("R7", "taskfile index", 32'(ix), 32'(r));
                check("R10", "taskfile read data", 32'(rd), 0);
            end
            acc(1'b0, EXT | (15'h2000 + 15'(c * 'h1000) + 15'h0060),
                8'h00, 1, cs, rd, ix, ns);
            check("R7", "off-stride offset", 32'(cs), 0);
        end
    endtask

    task automatic t_ctl_irq;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        for (int c = 0; c < 2; c++) begin
            acc(1'b0, EXT | (15'h2380 + 15'(c * 'h1000)), 8'h00, 1, cs, rd, ix, ns);
            check("R8", "control select", 32'(cs), 32'(1 << (4 + c)));
            check("R10", "control read data", 32'(rd), 0);
            acc(1'b1, EXT | (15'h2200 + 15'(c * 'h1000)), 8'h00, 1, cs, rd, ix, ns);
            check("R8", "irq mask select", 32'(cs), 32'(1 << (6 + c)));
            acc(1'b0, EXT | (15'h2290 + 15'(c * 'h1000)), 8'h00, 1, cs, rd, ix, ns);
            check("R8", "irq status select", 32'(cs), 32'(1 << (8 + c)));
        end
    endtask

    task automatic t_undecoded;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        acc(1'b0, EXT | 15'h1000, 8'h00, 1, cs, rd, ix, ns);
        check("R3", "ext hole select", 32'(cs), 0);
        acc(1'b0, 15'h0004, 8'h00, 1, cs, rd, ix, ns);
        check("R3", "fast hole select", 32'(cs), 0);
        check("R3", "fast hole data", 32'(rd), 0);
        acc(1'b0, EXT | 15'h2284, 8'h00, 1, cs, rd, ix, ns);
        check("R3", "ext offset 0x2284 hole", 32'(cs), 0);
    endtask

    task automatic t_hold;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        acc(1'b0, EXT | 15'h3000, 8'h00, 5, cs, rd, ix, ns);
        check("R2", "held strobe first select", 32'(cs), 32'h008);
        check("R2", "held strobe select cycles", 32'(ns), 1);
    endtask

    task automatic t_both;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        int seen;
        seen = 0;
        @(negedge clk);
        bus_addr = 15'h0000; bus_wdata = 8'h00; bus_rd = 1'b1; bus_wr = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (cs_vec != '0) seen++;
        end
        bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        check("R2", "rd+wr selects nothing", 32'(seen), 0);
        check("R2", "rd+wr leaves ext_en", 32'(ext_en), 1);
        acc(1'b0, 15'h0000, 8'h00, 1, cs, rd, ix, ns);
        check("R2", "rd+wr leaves cfg", 32'(rd), 32'h20);
    endtask

    task automatic t_restore;
        logic [9:0] cs; logic [7:0] rd; logic [2:0] ix; int ns;
        acc(1'b1, 15'h0000, 8'h00, 1, cs, rd, ix, ns);
        check("R6", "ext_en after clearing cfg", 32'(ext_en), 0);
        acc(1'b0, EXT | 15'h2000, 8'h00, 1, cs, rd, ix, ns);
        check("R6", "window closed again", 32'(cs), 0);
        acc(1'b0, 15'h2280, 8'h00, 1, cs, rd, ix, ns);
        check("R9", "ident readable again", 32'(rd), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ident;
        t_ext_gated;
        t_cfg;
        t_taskfile;
        t_ctl_irq;
        t_undecoded;
        t_hold;
        t_both;
        t_restore;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule